// File: doc/BRIEF.md
# Pipelined Signed Multiply-Accumulate Unit

This block keeps a wide running sum. On every clock edge where the enable is high, it multiplies two signed operands. It then adds that product to the sum or subtracts it from the sum, and adds a one-bit carry on top. A direction select and a carry input travel with each operand pair, so the choice can change on every cycle. The sum is returned on P.

Parameters set the width of each operand, the width of the sum and the total latency. The latency value decides where the registers are placed:

- input register stages, none, one or two deep;
- one accumulate register;
- an optional output register after the accumulate register.

Reset is synchronous and clears every stage. When the enable is low, every stage holds its value. Parameter values out of range stop elaboration with a fatal message.

Top module: `mac_pipe`

## Requirements
- R1: The cycle after an edge with `rst` high, `p` reads zero.
- R2: The register layout depends on the latency L:
  - L=1: no input stage and no output stage.
  - L=2: one input stage, no output stage.
  - L=3: one input stage and one output stage.
  - L=4: two input stages and one output stage.
  - Every setting has one accumulate stage.
  - An operand set sampled on an enabled edge first shows in `p` after the L-th enabled edge, counting its own edge as the first.
- R3: If `add_sel` is 1, the accumulate stage adds the product to the sum. If it is 0, the stage subtracts the product. The select travels with its own operand pair through the input stages.
- R4: `carry_in` adds 1 to the result of its own operand pair, after the add or subtract. The carry travels through the same stages as that pair.
- R5: `a` and `b` are two's-complement signed values. The product is sign-extended to WIDTH_P bits, and the sum wraps modulo 2^WIDTH_P.
- R6: While `ce` is low, every stage holds its value, including `p`. The inputs present during those cycles have no effect.
- R7: `rst` clears every stage even while `ce` is low. After the reset, no earlier operand affects the sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable, active high |
| a | input | WIDTH_A | Signed operand A |
| b | input | WIDTH_B | Signed operand B |
| add_sel | input | 1 | 1 = add product, 0 = subtract product |
| carry_in | input | 1 | Carry added into the result |
| p | output | WIDTH_P | Accumulated sum |

## Verification
All four latency settings run side by side on the same stimulus. This makes any difference in stage placement show up as a cycle offset against each setting's own reference.

The test patterns and what each one separates are:

- A single pulse followed by zero operands isolates the latency count.
- Random operands with a random direction and no carry check the add and subtract paths and the alignment of the select.
- Runs with the carry set separate an aligned carry from a shifted one.
- Repeated extreme-magnitude products drive the sum across its wrap point, which exposes sign-extension errors.
- Random inputs with the enable low, and resets with the enable low, show whether any stage leaks or keeps old history.

// File: rtl/mac_pkg.sv
package mac_pkg;
   // number of input register stages for a given latency
   function automatic int unsigned in_depth(input int unsigned lat);
      case (lat)
         1:       return 0;
         4:       return 2;
         default: return 1;
      endcase
   endfunction

   // output register present for a given latency
   function automatic int unsigned out_depth(input int unsigned lat);
      return (lat >= 3) ? 1 : 0;
   endfunction
endpackage

// File: rtl/mac_stage_reg.sv
module mac_stage_reg #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         ce,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk) begin
      if (rst)     q <= '0;
      else if (ce) q <= d;
   end

   // R7: reset clears the stage regardless of enable
   a_r7_stage_clear: assert property (@(posedge clk) rst |=> q == '0);
   // R6: a disabled stage keeps its contents
   a_r6_stage_hold: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(q));
endmodule

// File: rtl/mac_accum.sv
module mac_accum #(
   parameter int unsigned WA = 25,
   parameter int unsigned WB = 18,
   parameter int unsigned WP = 48
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 ce,
   input  logic signed [WA-1:0] opa,
   input  logic signed [WB-1:0] opb,
   input  logic                 add_en,
   input  logic                 cin,
   output logic [WP-1:0]        acc
);
   localparam int unsigned PW = WA + WB;
   localparam int unsigned EW = (WP > PW) ? WP : PW;

   logic signed [PW-1:0] prod;
   logic signed [EW-1:0] prod_ext;
   logic [WP-1:0]        term;
   logic [WP-1:0]        acc_nx;

   assign prod     = PW'(opa) * PW'(opb);
   assign prod_ext = EW'(prod);
   assign term     = prod_ext[WP-1:0];
   assign acc_nx   = (add_en ? (acc + term) : (acc - term)) + WP'(cin);

   always_ff @(posedge clk) begin
      if (rst)     acc <= '0;
      else if (ce) acc <= acc_nx;
   end

   // R3: a zero operand with no carry leaves the sum unchanged in either direction
   a_r3_zero_term: assert property (@(posedge clk) disable iff (rst)
      (ce && opa == '0 && !cin) |=> $stable(acc));
   // R4: a zero product with carry set advances the sum by exactly one
   a_r4_carry_step: assert property (@(posedge clk) disable iff (rst)
      (ce && opa == '0 && cin) |=> acc == $past(acc) + WP'(1));
endmodule

// File: rtl/mac_pipe.sv
module mac_pipe #(
   parameter int unsigned WIDTH_A = 25,
   parameter int unsigned WIDTH_B = 18,
   parameter int unsigned WIDTH_P = 48,
   parameter int unsigned LATENCY = 3
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ce,
   input  logic [WIDTH_A-1:0] a,
   input  logic [WIDTH_B-1:0] b,
   input  logic               add_sel,
   input  logic               carry_in,
   output logic [WIDTH_P-1:0] p
);
   import mac_pkg::*;

   localparam int unsigned NIN  = in_depth(LATENCY);
   localparam int unsigned NOUT = out_depth(LATENCY);
   localparam int unsigned BW   = WIDTH_A + WIDTH_B + 2;

   // elaboration-time parameter checks
   if (WIDTH_A < 1 || WIDTH_A > 25) begin : g_bad_wa
      $fatal(1, "mac_pipe: WIDTH_A must be 1..25");
   end
   if (WIDTH_B < 1 || WIDTH_B > 18) begin : g_bad_wb
      $fatal(1, "mac_pipe: WIDTH_B must be 1..18");
   end
   if (WIDTH_P < 1 || WIDTH_P > 48) begin : g_bad_wp
      $fatal(1, "mac_pipe: WIDTH_P must be 1..48");
   end
   if (LATENCY < 1 || LATENCY > 4) begin : g_bad_lat
      $fatal(1, "mac_pipe: LATENCY must be 1..4");
   end

   // operands, direction and carry share one bus so they stay aligned
   logic [BW-1:0] chain [0:NIN];
   assign chain[0] = {add_sel, carry_in, a, b};

   for (genvar i = 0; i < NIN; i++) begin : g_in
      mac_stage_reg #(.W(BW)) u_in (
         .clk(clk), .rst(rst), .ce(ce), .d(chain[i]), .q(chain[i+1])
      );
   end

   logic [WIDTH_A-1:0] st_a;
   logic [WIDTH_B-1:0] st_b;
   logic               st_add;
   logic               st_ci;
   logic [WIDTH_P-1:0] acc;

   assign {st_add, st_ci, st_a, st_b} = chain[NIN];

   mac_accum #(.WA(WIDTH_A), .WB(WIDTH_B), .WP(WIDTH_P)) u_acc (
      .clk(clk), .rst(rst), .ce(ce),
      .opa(st_a), .opb(st_b), .add_en(st_add), .cin(st_ci),
      .acc(acc)
   );

   if (NOUT != 0) begin : g_out
      mac_stage_reg #(.W(WIDTH_P)) u_out (
         .clk(clk), .rst(rst), .ce(ce), .d(acc), .q(p)
      );
   end else begin : g_no_out
      assign p = acc;
   end

   // R1: output reads zero after a reset edge
   a_r1_out_zero: assert property (@(posedge clk) rst |=> p == '0);
   // R6: output frozen while disabled
   a_r6_out_hold: assert property (@(posedge clk) disable iff (rst)
      !ce |=> $stable(p));
endmodule

// File: tb/mac_pipe_bench.sv
module mac_pipe_bench;
   localparam int CLK_P = 10;
   localparam int WA = 25, WB = 18, WP = 48;

   logic clk = 1'b0;
   logic rst = 1'b1, ce = 1'b0, add_sel = 1'b1, carry_in = 1'b0;
   logic [WA-1:0] a = '0;
   logic [WB-1:0] b = '0;
   logic [WP-1:0] p_arr [4];

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_P/2) clk = ~clk;

   for (genvar g = 0; g < 4; g++) begin : g_dut
      if (g == 2) begin : g_main
         mac_pipe #(.WIDTH_A(WA), .WIDTH_B(WB), .WIDTH_P(WP), .LATENCY(3)) u_mac_pipe (
            .clk(clk), .rst(rst), .ce(ce), .a(a), .b(b),
            .add_sel(add_sel), .carry_in(carry_in), .p(p_arr[g]));
      end else begin : g_alt
         mac_pipe #(.WIDTH_A(WA), .WIDTH_B(WB), .WIDTH_P(WP), .LATENCY(g+1)) u_mac_pipe (
            .clk(clk), .rst(rst), .ce(ce), .a(a), .b(b),
            .add_sel(add_sel), .carry_in(carry_in), .p(p_arr[g]));
      end
   end

   // reference state per latency
   logic [WA-1:0] m_a   [4][2];
   logic [WB-1:0] m_b   [4][2];
   logic          m_add [4][2];
   logic          m_ci  [4][2];
   logic [WP-1:0] m_acc [4];
   logic [WP-1:0] m_out [4];

   function automatic logic [WP-1:0] ref_mac(input logic [WP-1:0] s,
      input logic [WA-1:0] x, input logic [WB-1:0] y, input logic ad, input logic c);
      longint sx, sy, pr, t;
      sx = longint'($signed(x));
      sy = longint'($signed(y));
      pr = sx * sy;
      t  = ad ? (longint'(s) + pr) : (longint'(s) - pr);
      t  = t + longint'(c);
      return t[WP-1:0];
   endfunction

   // predict state after the coming rising edge
   task automatic model_edge();
      for (int l = 0; l < 4; l++) begin
         int ni;
         logic [WA-1:0] xa; logic [WB-1:0] xb; logic xd, xc;
         ni = (l == 0) ? 0 : (l == 3) ? 2 : 1;
         if (rst) begin
            for (int k = 0; k < 2; k++) begin
               m_a[l][k] = '0; m_b[l][k] = '0; m_add[l][k] = 0; m_ci[l][k] = 0;
            end
            m_acc[l] = '0; m_out[l] = '0;
         end else if (ce) begin
            if (ni == 0) begin xa = a; xb = b; xd = add_sel; xc = carry_in; end
            else begin
               xa = m_a[l][ni-1]; xb = m_b[l][ni-1]; xd = m_add[l][ni-1]; xc = m_ci[l][ni-1];
            end
            m_out[l] = m_acc[l];
            m_a[l][1] = m_a[l][0]; m_b[l][1] = m_b[l][0];
            m_add[l][1] = m_add[l][0]; m_ci[l][1] = m_ci[l][0];
            m_a[l][0] = a; m_b[l][0] = b; m_add[l][0] = add_sel; m_ci[l][0] = carry_in;
            m_acc[l] = ref_mac(m_acc[l], xa, xb, xd, xc);
         end
      end
   endtask

   task automatic step(input string tag);
      model_edge();
      @(negedge clk);
      for (int l = 0; l < 4; l++) begin
         logic [WP-1:0] exp_p;
         exp_p = (l >= 2) ? m_out[l] : m_acc[l];
         n_run++;
         if (p_arr[l] !== exp_p) begin
            n_fail++;
            $display("FAIL %s latency=%0d got %h expected %h", tag, l+1, p_arr[l], exp_p);
         end
      end
   endtask

   task automatic drive(input logic [WA-1:0] xa, input logic [WB-1:0] xb,
      input logic xd, input logic xc);
      a = xa; b = xb; add_sel = xd; carry_in = xc;
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      @(negedge clk);
      // R1: reset state
      rst = 1; ce = 0;
      step("R1"); step("R1");
      rst = 0; ce = 1;
      // R2: single pulse, then zero ops
      drive(25'd3, 18'd5, 1, 0); step("R2");
      for (int i = 0; i < 6; i++) begin drive('0, '0, 1, 0); step("R2"); end
      // R3: mixed add/subtract, no carry
      for (int i = 0; i < 40; i++) begin
         drive(WA'($urandom), WB'($urandom), 1'($urandom), 0); step("R3");
      end
      // R4: carry runs, including zero products
      for (int i = 0; i < 20; i++) begin
         drive(WA'($urandom), WB'($urandom), 1'($urandom), 1); step("R4");
      end
      for (int i = 0; i < 5; i++) begin drive('0, WB'($urandom), 0, 1); step("R4"); end
      // R5: extreme magnitudes drive the sum across its wrap
      for (int i = 0; i < 140; i++) begin
         drive({1'b1, {(WA-1){1'b0}}}, {1'b1, {(WB-1){1'b0}}}, 1, 0); step("R5");
      end
      for (int i = 0; i < 140; i++) begin
         drive({1'b1, {(WA-1){1'b0}}}, {1'b0, {(WB-1){1'b1}}}, i[0], i[1]); step("R5");
      end
      // R6: enable low holds everything
      ce = 0;
      for (int i = 0; i < 10; i++) begin
         drive(WA'($urandom), WB'($urandom), 1'($urandom), 1'($urandom)); step("R6");
      end
      for (int i = 0; i < 30; i++) begin
         ce = 1'($urandom);
         drive(WA'($urandom), WB'($urandom), 1'($urandom), 1'($urandom)); step("R6");
      end
      // R7: reset with enable low clears all history
      ce = 0; rst = 1;
      drive(WA'($urandom), WB'($urandom), 1, 1); step("R7");
      rst = 0; ce = 1;
      for (int i = 0; i < 20; i++) begin
         drive(WA'($urandom), WB'($urandom), 1'($urandom), 1'($urandom)); step("R7");
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      #(CLK_P * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end
endmodule